// File: doc/BRIEF.md
# Pipelined Zero-Turnaround Synchronous Memory

This block is a synchronous, pipelined, 18-bit-wide storage array. It takes one command on every enabled clock edge: a read, a write, a burst continuation or a deselect. Write data trails its command by the same distance that read data trails its command. A stream of reads and writes can therefore alternate every cycle with no idle slots. Read data leaves through an output register. Write data is captured into a one-entry write buffer and reaches the array one enabled edge later. A bypass path keeps a read that follows closely behind a write coherent with that write.

The word is split into two 9-bit byte lanes. Each lane has its own active-low write enable. A clock enable freezes the whole pipeline. Three chip selects must all be active for a command to count. A load/advance input picks between a new external address and the next beat of a four-beat burst, and the burst order is either linear or interleaved. The output enable gates the data drive without waiting for a clock edge. A sleep input makes the block ignore commands. The data port is split into an input bus, an output bus and a drive-enable output.

Top module: `pipe_nt_sram`

## Requirements
- R1: After reset, with no command in flight, `dout_en` is 0.
- R2: A selected read load captured at an enabled edge E0 is driven onto `dout` after the second following enabled edge (E2), with `dout_en` = 1 while `oe_n` is low.
- R3: For a selected write load captured at enabled edge E0, `din` is sampled at E2 and stored. A later read of that address returns the stored data. A write never causes `dout_en` to rise.
- R4: `lane_we_n[0]` (active low) guards bits 8:0 and `lane_we_n[1]` guards bits 17:9. Both low is a full-word write. Both high leaves the word unchanged. The lane enables are sampled with the command.
- R5: A read issued in the cycle right after a write to the same address returns the new data, merged per lane with the old word.
- R6: Writes and reads to different addresses can alternate on every cycle with no idle cycle, and every read returns the correct data.
- R7: While `cke_n` is high, no edge advances the pipeline. `dout` holds its value, and a command on the pins during that time has no effect.
- R8: The block is selected only when `cs0_n`=0, `cs1`=1 and `cs2_n`=0. Any other load is a deselect: it does not change the array and produces no drive.
- R9: With `adv`=1, the operation of the last load repeats at the next burst address. With `lin`=1 sampled at the load, address bits 1:0 are (start + beat) mod 4, and the upper bits stay fixed. `lin` is ignored on advance cycles.
- R10: With `lin`=0 sampled at the load, address bits 1:0 of beat n are the start bits XOR n.
- R11: `oe_n` high forces `dout_en` to 0 at once, without a clock edge. Lowering it again restores the drive of pending read data.
- R12: While `sleep` is high, commands are ignored. An advance issued right after sleep counts as a deselect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset of control state |
| cke_n | input | 1 | Active-low clock enable |
| cs0_n | input | 1 | Chip select, active low |
| cs1 | input | 1 | Chip select, active high |
| cs2_n | input | 1 | Chip select, active low |
| rd_nwr | input | 1 | 1 = read, 0 = write (on loads) |
| lane_we_n | input | 2 | Per-lane active-low write enables |
| adv | input | 1 | 1 = advance burst, 0 = load address |
| lin | input | 1 | Burst order at load: 1 linear, 0 interleaved |
| oe_n | input | 1 | Asynchronous active-low output enable |
| sleep | input | 1 | Standby: ignore commands |
| addr | input | 8 | Word address |
| din | input | 18 | Write data |
| dout | output | 18 | Registered read data |
| dout_en | output | 1 | Output drive enable |

## Verification
The latency properties assume that every input is at a known level on each sampled edge and that reset is applied once before traffic starts. They look back three samples only after a counter shows that three edges have passed since reset. Data values are left to the bench. Its reference model has to write an address in full before reading it, because the array itself is never cleared. The bench changes `din` only on the enabled edge at which write data is due, and it holds `din` steady across stalls. It toggles `oe_n` only between edges, so the asynchronous gating is observed apart from any clocked update.

// File: rtl/pipe_nt_sram.sv
module pipe_nt_sram #(
  parameter int AW    = 8,
  parameter int LW    = 9,
  parameter int LANES = 2
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                cke_n,
  input  logic                cs0_n,
  input  logic                cs1,
  input  logic                cs2_n,
  input  logic                rd_nwr,
  input  logic [LANES-1:0]    lane_we_n,
  input  logic                adv,
  input  logic                lin,
  input  logic                oe_n,
  input  logic                sleep,
  input  logic [AW-1:0]       addr,
  input  logic [LANES*LW-1:0] din,
  output logic [LANES*LW-1:0] dout,
  output logic                dout_en
);
  localparam int DW    = LANES * LW;
  localparam int DEPTH = 1 << AW;
  localparam logic [1:0] OP_IDLE = 2'd0, OP_RD = 2'd1, OP_WR = 2'd2;

  logic [DW-1:0] mem [DEPTH];

  logic             go;
  logic             selected;
  logic [1:0]       b_op, n_op;
  logic [AW-1:0]    b_base, n_base;
  logic [1:0]       b_cnt, n_cnt, eff_lo;
  logic             b_lin, n_lin;
  logic [AW-1:0]    eff_addr;

  logic [1:0]       s1_op, s2_op;
  logic [AW-1:0]    s1_addr, s2_addr;
  logic [LANES-1:0] s1_we_n, s2_we_n;

  logic             wb_v;
  logic [AW-1:0]    wb_addr;
  logic [DW-1:0]    wb_data;
  logic [LANES-1:0] wb_lane;

  logic [DW-1:0]    rd_word;
  logic [DW-1:0]    q;
  logic             q_v;

  assign go       = !cke_n;
  assign selected = !cs0_n && cs1 && !cs2_n;

  always_comb begin
    n_op   = b_op;
    n_base = b_base;
    n_cnt  = b_cnt + 2'd1;
    n_lin  = b_lin;
    if (sleep) begin
      n_op = OP_IDLE;
    end else if (!adv) begin
      n_op   = selected ? (rd_nwr ? OP_RD : OP_WR) : OP_IDLE;
      n_base = addr;
      n_cnt  = 2'd0;
      n_lin  = lin;
    end
    eff_lo   = n_lin ? (n_base[1:0] + n_cnt) : (n_base[1:0] ^ n_cnt);
    eff_addr = {n_base[AW-1:2], eff_lo};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      b_op <= OP_IDLE; b_base <= '0; b_cnt <= '0; b_lin <= 1'b1;
      s1_op <= OP_IDLE; s1_addr <= '0; s1_we_n <= '1;
      s2_op <= OP_IDLE; s2_addr <= '0; s2_we_n <= '1;
      wb_v <= 1'b0; wb_addr <= '0; wb_data <= '0; wb_lane <= '0;
      q <= '0; q_v <= 1'b0;
    end else if (go) begin
      b_op    <= n_op;
      b_base  <= n_base;
      b_cnt   <= n_cnt;
      b_lin   <= n_lin;
      s1_op   <= n_op;
      s1_addr <= eff_addr;
      s1_we_n <= lane_we_n;
      s2_op   <= s1_op;
      s2_addr <= s1_addr;
      s2_we_n <= s1_we_n;
      wb_v    <= (s2_op == OP_WR);
      if (s2_op == OP_WR) begin
        wb_addr <= s2_addr;
        wb_data <= din;
        wb_lane <= ~s2_we_n;
      end
      q_v <= (s2_op == OP_RD);
      if (s2_op == OP_RD) q <= rd_word;
    end
  end

  for (genvar i = 0; i < LANES; i++) begin : g_lane
    assign rd_word[i*LW +: LW] = (wb_v && wb_lane[i] && wb_addr == s2_addr)
                                 ? wb_data[i*LW +: LW] : mem[s2_addr][i*LW +: LW];
  end

  always_ff @(posedge clk) begin
    if (go && wb_v) begin
      for (int i = 0; i < LANES; i++) begin
        if (wb_lane[i]) mem[wb_addr][i*LW +: LW] <= wb_data[i*LW +: LW];
      end
    end
  end

  assign dout    = q;
  assign dout_en = q_v && !oe_n;
endmodule

// File: rtl/pipe_nt_sram_chk.sv
module pipe_nt_sram_chk #(
  parameter int DW = 18
) (
  input logic          clk,
  input logic          rst_n,
  input logic          cke_n,
  input logic          cs0_n,
  input logic          cs1,
  input logic          cs2_n,
  input logic          rd_nwr,
  input logic          adv,
  input logic          oe_n,
  input logic          sleep,
  input logic [DW-1:0] dout,
  input logic          dout_en
);
  logic [1:0] since_rst;
  logic sel, rd_load, wr_load, ds_load, warm;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) since_rst <= 2'd0;
    else if (since_rst != 2'd3) since_rst <= since_rst + 2'd1;
  end

  assign warm    = (since_rst == 2'd3);
  assign sel     = !cs0_n && cs1 && !cs2_n;
  assign rd_load = !cke_n && !sleep && !adv && sel && rd_nwr;
  assign wr_load = !cke_n && !sleep && !adv && sel && !rd_nwr;
  assign ds_load = !cke_n && !sleep && !adv && !sel;

  p_oe_gate_r11: assert property (@(posedge clk) disable iff (!rst_n)
    oe_n |-> !dout_en);

  p_freeze_r7: assert property (@(posedge clk) disable iff (!rst_n)
    cke_n |=> $stable(dout));

  p_read_lat_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (warm && $past(rd_load, 3) && $past(!cke_n, 2) && $past(!cke_n, 1))
      |-> (dout_en || oe_n));

  p_write_quiet_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (warm && $past(wr_load, 3) && $past(!cke_n, 2) && $past(!cke_n, 1))
      |-> !dout_en);

  p_desel_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (warm && $past(ds_load, 3) && $past(!cke_n, 2) && $past(!cke_n, 1))
      |-> !dout_en);

  p_sleep_quiet_r12: assert property (@(posedge clk) disable iff (!rst_n)
    (warm && $past(sleep && !cke_n, 3) && $past(!cke_n, 2) && $past(!cke_n, 1))
      |-> !dout_en);
endmodule

bind pipe_nt_sram pipe_nt_sram_chk #(.DW(LANES*LW)) chk_i (
  .clk(clk), .rst_n(rst_n), .cke_n(cke_n), .cs0_n(cs0_n), .cs1(cs1),
  .cs2_n(cs2_n), .rd_nwr(rd_nwr), .adv(adv), .oe_n(oe_n), .sleep(sleep),
  .dout(dout), .dout_en(dout_en)
);

// File: tb/pipe_nt_sram_tb_top.sv
`timescale 1ns/1ps
module pipe_nt_sram_tb_top;
  localparam int AW = 8;
  localparam int DW = 18;

  logic clk = 1'b0;
  logic rst_n, cke_n, cs0_n, cs1, cs2_n, rd_nwr, adv, lin, oe_n, sleep;
  logic [1:0]    lane_we_n;
  logic [AW-1:0] addr;
  logic [DW-1:0] din, dout;
  logic          dout_en;

  always #4 clk = ~clk;

  pipe_nt_sram dut_i (
    .clk(clk), .rst_n(rst_n), .cke_n(cke_n), .cs0_n(cs0_n), .cs1(cs1),
    .cs2_n(cs2_n), .rd_nwr(rd_nwr), .lane_we_n(lane_we_n), .adv(adv),
    .lin(lin), .oe_n(oe_n), .sleep(sleep), .addr(addr), .din(din),
    .dout(dout), .dout_en(dout_en)
  );

  int n_chk = 0, n_bad = 0, ecnt = 0;
  bit finished = 0;
  string cur_req = "R1";

  logic [DW-1:0] ref_mem [256];
  logic [DW-1:0] din_sl [16];
  bit            din_v  [16];
  logic [DW-1:0] exp_sl [16];
  bit            exp_v  [16];
  string         exp_tag[16];

  logic [1:0]    r_op, r_cnt;
  logic [AW-1:0] r_base;
  logic          r_lin;

  task automatic chk(input string req, input string what, input logic [DW-1:0] act, input logic [DW-1:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic step();
    bit en;
    int k;
    en = !cke_n;
    @(negedge clk);
    if (en) begin
      ecnt++;
      k = ecnt % 16;
      if (din_v[k]) begin din = din_sl[k]; din_v[k] = 0; end
      if (exp_v[k]) begin
        chk(exp_tag[k], "read drive", {17'd0, dout_en}, {17'd0, !oe_n});
        chk(exp_tag[k], "read data", dout, exp_sl[k]);
      end else begin
        chk(cur_req, "no drive", {17'd0, dout_en}, 18'd0);
      end
      exp_v[k] = 0;
    end
  endtask

  task automatic cmd(input bit rd, input bit adv_i, input bit lin_i, input logic [2:0] cs,
                     input logic [AW-1:0] a, input logic [1:0] we, input logic [DW-1:0] wd);
    logic [1:0] lo;
    logic [AW-1:0] ea;
    int k2, k3;
    {cs0_n, cs1, cs2_n} = cs;
    rd_nwr = rd; adv = adv_i; lin = lin_i; addr = a; lane_we_n = we;
    if (sleep) r_op = 2'd0;
    else if (!adv_i) begin
      r_op = (cs == 3'b010) ? (rd ? 2'd1 : 2'd2) : 2'd0;
      r_base = a; r_cnt = 2'd0; r_lin = lin_i;
    end else r_cnt = r_cnt + 2'd1;
    lo = r_lin ? (r_base[1:0] + r_cnt) : (r_base[1:0] ^ r_cnt);
    ea = {r_base[AW-1:2], lo};
    k2 = (ecnt + 2) % 16;
    k3 = (ecnt + 3) % 16;
    if (r_op == 2'd2) begin
      if (!we[0]) ref_mem[ea][8:0]  = wd[8:0];
      if (!we[1]) ref_mem[ea][17:9] = wd[17:9];
      din_sl[k2] = wd; din_v[k2] = 1;
    end else if (r_op == 2'd1) begin
      exp_sl[k3] = ref_mem[ea]; exp_v[k3] = 1; exp_tag[k3] = cur_req;
    end
    step();
  endtask

  task automatic wr(input logic [AW-1:0] a, input logic [1:0] we, input logic [DW-1:0] wd);
    cmd(1'b0, 1'b0, 1'b1, 3'b010, a, we, wd);
  endtask
  task automatic rd(input logic [AW-1:0] a);
    cmd(1'b1, 1'b0, 1'b1, 3'b010, a, 2'b11, '0);
  endtask
  task automatic idle(input int n);
    for (int i = 0; i < n; i++) cmd(1'b1, 1'b0, 1'b1, 3'b110, '0, 2'b11, '0);
  endtask

  task automatic t_reset();
    cur_req = "R1";
    rst_n = 0; cke_n = 0; cs0_n = 1; cs1 = 1; cs2_n = 0; rd_nwr = 1; adv = 0;
    lin = 1; oe_n = 0; sleep = 0; addr = '0; lane_we_n = 2'b11; din = '0;
    r_op = 0; r_cnt = 0; r_base = '0; r_lin = 1;
    for (int i = 0; i < 16; i++) begin din_v[i] = 0; exp_v[i] = 0; end
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk("R1", "dout_en after reset", {17'd0, dout_en}, 18'd0);
    idle(3);
  endtask

  task automatic t_write_read();
    cur_req = "R3";
    for (int i = 0; i < 48; i++) wr(i[AW-1:0], 2'b00, 18'h15a00 ^ (i * 18'h0411));
    idle(3);
    for (int i = 0; i < 8; i++) rd(i[AW-1:0]);
    idle(4);
  endtask

  task automatic t_lanes();
    cur_req = "R4";
    wr(8'd0, 2'b10, 18'h3ffff);
    wr(8'd1, 2'b01, 18'h3ffff);
    wr(8'd2, 2'b11, 18'h3ffff);
    idle(3);
    rd(8'd0); rd(8'd1); rd(8'd2);
    idle(4);
  endtask

  task automatic t_bypass();
    cur_req = "R5";
    wr(8'd3, 2'b10, 18'h00077);
    rd(8'd3);
    wr(8'd4, 2'b01, 18'h2aa00);
    rd(8'd4);
    wr(8'd5, 2'b00, 18'h1c3c3);
    wr(8'd5, 2'b10, 18'h00011);
    rd(8'd5);
    idle(4);
  endtask

  task automatic t_alternate();
    cur_req = "R6";
    for (int i = 0; i < 8; i++) begin
      wr(8'd16 + i[AW-1:0], 2'b00, 18'h20000 + i * 18'h111);
      rd(8'd24 + i[AW-1:0]);
    end
    idle(4);
  endtask

  task automatic t_stall();
    logic [DW-1:0] held;
    cur_req = "R7";
    rd(8'd16);
    idle(1);
    held = dout;
    cke_n = 1;
    {cs0_n, cs1, cs2_n} = 3'b010; rd_nwr = 0; adv = 0; addr = 8'd6; lane_we_n = 2'b00;
    for (int i = 0; i < 3; i++) begin
      step();
      chk("R7", "dout frozen", dout, held);
    end
    cke_n = 0;
    idle(3);
    rd(8'd6);
    idle(4);
  endtask

  task automatic t_desel();
    cur_req = "R8";
    cmd(1'b0, 1'b0, 1'b1, 3'b110, 8'd7, 2'b00, 18'h0dead);
    cmd(1'b0, 1'b0, 1'b1, 3'b000, 8'd7, 2'b00, 18'h0beef);
    cmd(1'b0, 1'b0, 1'b1, 3'b011, 8'd7, 2'b00, 18'h0cafe);
    cmd(1'b1, 1'b0, 1'b1, 3'b100, 8'd7, 2'b11, '0);
    idle(3);
    rd(8'd7);
    idle(4);
  endtask

  task automatic t_burst();
    cur_req = "R9";
    cmd(1'b0, 1'b0, 1'b1, 3'b010, 8'd34, 2'b00, 18'h10001);
    cmd(1'b0, 1'b1, 1'b0, 3'b010, 8'd0,  2'b00, 18'h10002);
    cmd(1'b0, 1'b1, 1'b0, 3'b010, 8'd0,  2'b00, 18'h10003);
    cmd(1'b0, 1'b1, 1'b0, 3'b010, 8'd0,  2'b00, 18'h10004);
    idle(3);
    cmd(1'b1, 1'b0, 1'b1, 3'b010, 8'd33, 2'b11, '0);
    for (int i = 0; i < 3; i++) cmd(1'b1, 1'b1, 1'b0, 3'b110, 8'd0, 2'b11, '0);
    idle(4);
    cur_req = "R10";
    cmd(1'b0, 1'b0, 1'b0, 3'b010, 8'd38, 2'b00, 18'h20001);
    for (int i = 0; i < 3; i++) cmd(1'b0, 1'b1, 1'b1, 3'b110, 8'd0, 2'b00, 18'h20002 + i);
    idle(3);
    cmd(1'b1, 1'b0, 1'b0, 3'b010, 8'd33, 2'b11, '0);
    for (int i = 0; i < 3; i++) cmd(1'b1, 1'b1, 1'b1, 3'b010, 8'd0, 2'b11, '0);
    cmd(1'b1, 1'b0, 1'b1, 3'b010, 8'd36, 2'b11, '0);
    for (int i = 0; i < 3; i++) cmd(1'b1, 1'b1, 1'b0, 3'b010, 8'd0, 2'b11, '0);
    idle(4);
  endtask

  task automatic t_oe();
    cur_req = "R11";
    rd(8'd1);
    idle(1);
    oe_n = 1;
    idle(1);
    chk("R11", "drive off while oe_n high", {17'd0, dout_en}, 18'd0);
    oe_n = 0; #1;
    chk("R11", "drive on after oe_n low", {17'd0, dout_en}, 18'd1);
    chk("R11", "data under oe", dout, ref_mem[1]);
    oe_n = 1; #1;
    chk("R11", "drive off again", {17'd0, dout_en}, 18'd0);
    oe_n = 0; #1;
    idle(4);
  endtask

  task automatic t_sleep();
    cur_req = "R12";
    sleep = 1;
    wr(8'd8, 2'b00, 18'h3aaaa);
    rd(8'd8);
    sleep = 0;
    cmd(1'b1, 1'b1, 1'b1, 3'b010, 8'd8, 2'b11, '0);
    idle(3);
    rd(8'd8);
    idle(4);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      n_chk++; n_bad++;
      $display("FAIL R2 watchdog: actual=timeout expected=completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    t_reset();
    t_write_read();
    t_lanes();
    t_bypass();
    t_alternate();
    t_stall();
    t_desel();
    t_burst();
    t_oe();
    t_sleep();
    finished = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule